// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the instruction pipeline of a small processor core. It decides whether and when an interrupt is taken, then runs the entry sequence on its own. First it pushes the flag word, the code segment and the instruction pointer onto the stack. It then reads the handler's offset and segment from the vector table and loads them into the core as the new program counter. It also runs the matching return sequence. That sequence pops the instruction pointer, the code segment and the flags, and hands them back to the core.

There are three kinds of request: a maskable level request, a non-maskable input and a software interrupt that carries its own type number. Interrupts are taken only on the instruction-boundary strobe. The block holds the interrupt-enable bit and updates it from the core's clear-enable and set-enable commands. Only the maskable line is gated by that bit. When the maskable line is accepted, the block raises an acknowledge for one cycle and reads the type number from the acknowledge data bus. The non-maskable input always uses type 2. Stack pushes, stack pops and vector reads share one memory port with a single ready handshake. The vector for type `T` is the word at byte address `4*T` (the offset) and the word at `4*T+2` (the segment).

States: `ST_IDLE` (waiting), `ST_ACK` (acknowledge cycle), `ST_PUSH_FL`, `ST_PUSH_CS`, `ST_PUSH_IP` (entry pushes), `ST_VEC_OFS`, `ST_VEC_SEG` (vector reads), `ST_JUMP` (load the handler address), `ST_POP_IP`, `ST_POP_CS`, `ST_POP_FL` (return pops) and `ST_RESUME` (load the restored state).

Transitions:
- `ST_IDLE` to `ST_POP_IP` on a return request.
- `ST_IDLE` to `ST_PUSH_FL` on a boundary with a pending non-maskable or software request.
- `ST_IDLE` to `ST_ACK` on a boundary with an enabled maskable request.
- `ST_ACK` to `ST_PUSH_FL` after one cycle.
- Each push, vector and pop state moves to the next state in the chain when `mem_rdy` is high.
- `ST_VEC_SEG` goes to `ST_JUMP`, and `ST_POP_FL` goes to `ST_RESUME`.
- `ST_JUMP` and `ST_RESUME` return to `ST_IDLE` after one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the enable bit is 0 and the block is idle (`seq_busy` low). No acknowledge, memory or load strobe is active, and at most one of these strobes is ever active in the same cycle.
- R2: A new interrupt is taken only in a cycle where `insn_done` is high while idle. Requests held without the boundary strobe start nothing, and no memory strobe is active while idle.
- R3: While the enable bit is 0, the maskable line is ignored. The non-maskable input and software interrupts are taken whatever the enable bit holds.
- R4: While idle, `cli_cmd` writes 0 to the enable bit and `sti_cmd` writes 1. When both are high in the same cycle, the clear wins.
- R5: When a maskable request is accepted, `int_ack` is high for exactly one cycle, and `ack_type` is sampled as the type number in that cycle.
- R6: Entry pushes three words in this order: the flag word (`cur_flags` with bit 9 replaced by the enable bit), then `cur_cs`, then `cur_ip`.
- R7: After the pushes, the block reads byte address `4*type` as the handler offset and then `4*type+2` as the handler segment. It then pulses `pc_load` with `new_ip` and `new_cs` set to those two words.
- R8: A non-maskable entry uses type 2, so it reads addresses 8 and 10, and it raises no acknowledge.
- R9: A rising edge on `nmi_in` is latched. A one-cycle pulse that arrives between boundaries is taken at the next boundary.
- R10: Priority at one idle cycle, from highest to lowest: return request, non-maskable, software, maskable.
- R11: The enable bit is cleared once the flag word has been pushed, so the handler starts with the maskable line blocked.
- R12: A return request pops the instruction pointer, then the code segment, then the flags. It then pulses `pc_load` together with `flags_load`, carrying the popped values, and the enable bit takes bit 9 of the popped flags.
- R13: Each push, pop or vector read is held stable until `mem_rdy` is high, and each one completes exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_req | input | 1 | Maskable interrupt request (level) |
| nmi_in | input | 1 | Non-maskable interrupt input (edge) |
| swi_req | input | 1 | Software interrupt request from decode |
| swi_type | input | 8 | Type number of the software interrupt |
| insn_done | input | 1 | Instruction-boundary strobe |
| ret_req | input | 1 | Return-from-handler request |
| cli_cmd | input | 1 | Clear-enable command |
| sti_cmd | input | 1 | Set-enable command |
| int_ack | output | 1 | Interrupt acknowledge |
| ack_type | input | 8 | Type number on the data bus during the acknowledge |
| cur_flags | input | 16 | Core flag word to save |
| cur_cs | input | 16 | Core code segment to save |
| cur_ip | input | 16 | Core instruction pointer to save |
| stk_push | output | 1 | Stack push request |
| stk_pop | output | 1 | Stack pop request |
| vec_rd | output | 1 | Vector-table read request |
| mem_addr | output | 20 | Vector-table byte address |
| stk_wdata | output | 16 | Word to push |
| mem_rdata | input | 16 | Popped or vector word |
| mem_rdy | input | 1 | Memory completion |
| pc_load | output | 1 | Load `new_cs`:`new_ip` into the core |
| new_cs | output | 16 | Code segment to load |
| new_ip | output | 16 | Instruction pointer to load |
| flags_load | output | 1 | Load `flags_out` into the core |
| flags_out | output | 16 | Restored flag word |
| ie_flag | output | 1 | Interrupt-enable bit |
| seq_busy | output | 1 | Sequence in progress |

## Verification
Some priority cases are hard to reach from the ports. One is a non-maskable edge that is waiting while a return request and a boundary arrive in the same cycle. Another is a maskable request that is still asserted while a non-maskable or software entry starts. The bench pulses `nmi_in` for one cycle several cycles before any boundary, then raises `ret_req` and `insn_done` together. It checks that the whole pop sequence runs first and that the latched edge is still taken at the next boundary. The memory responder's latency is changed between scenarios, so the hold-until-ready behaviour is seen with zero, one, two and three wait cycles.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_OFS,
        ST_VEC_SEG,
        ST_JUMP,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_RESUME
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SWI,
        SRC_MASK
    } irq_src_e;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic take,
    output logic pending
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            nmi_q   <= nmi_in;
            pending <= (pending & ~take) | rise;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2
) (
    input  logic              nmi_pend,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              intr_req,
    input  logic              ie,
    output irq_src_e          src,
    output logic [TYPE_W-1:0] sel_type
);
    localparam logic [TYPE_W-1:0] NmiCode = TYPE_W'(NMI_TYPE);

    always_comb begin
        src      = SRC_NONE;
        sel_type = '0;
        if (nmi_pend) begin
            src      = SRC_NMI;
            sel_type = NmiCode;
        end else if (swi_req) begin
            src      = SRC_SWI;
            sel_type = swi_type;
        end else if (intr_req && ie) begin
            src      = SRC_MASK;
        end
    end
endmodule

// File: rtl/irq_ie_flag.sv
module irq_ie_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_en,
    input  logic cmd_clr,
    input  logic cmd_set,
    input  logic entry_clr,
    input  logic restore_en,
    input  logic restore_val,
    output logic ie
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b0;
        end else if (entry_clr) begin
            ie <= 1'b0;
        end else if (restore_en) begin
            ie <= restore_val;
        end else if (cmd_en && cmd_clr) begin
            ie <= 1'b0;
        end else if (cmd_en && cmd_set) begin
            ie <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8,
    parameter int IE_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              go_ret,
    input  irq_src_e          src,
    input  logic [TYPE_W-1:0] sel_type,
    input  logic [TYPE_W-1:0] ack_type,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic              ie,
    input  logic              mem_rdy,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              is_idle,
    output logic              nmi_take,
    output logic              entry_clr,
    output logic              restore_en,
    output logic              restore_val,
    output logic              int_ack,
    output logic              stk_push,
    output logic              stk_pop,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              pc_load,
    output logic              flags_load,
    output logic [DATA_W-1:0] new_ip,
    output logic [DATA_W-1:0] new_cs,
    output logic [DATA_W-1:0] flags_out
);
    localparam int PAD_W = ADDR_W - TYPE_W - 2;

    seq_state_e        state, state_n;
    logic [TYPE_W-1:0] vtype;
    logic [DATA_W-1:0] ip_buf, cs_buf, fl_buf;
    logic              take_irq;

    assign take_irq = (state == ST_IDLE) && !go_ret && insn_done && (src != SRC_NONE);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (go_ret) begin
                    state_n = ST_POP_IP;
                end else if (insn_done) begin
                    unique case (src)
                        SRC_NMI, SRC_SWI: state_n = ST_PUSH_FL;
                        SRC_MASK:         state_n = ST_ACK;
                        default:          state_n = ST_IDLE;
                    endcase
                end
            end
            ST_ACK:     state_n = ST_PUSH_FL;
            ST_PUSH_FL: if (mem_rdy) state_n = ST_PUSH_CS;
            ST_PUSH_CS: if (mem_rdy) state_n = ST_PUSH_IP;
            ST_PUSH_IP: if (mem_rdy) state_n = ST_VEC_OFS;
            ST_VEC_OFS: if (mem_rdy) state_n = ST_VEC_SEG;
            ST_VEC_SEG: if (mem_rdy) state_n = ST_JUMP;
            ST_JUMP:    state_n = ST_IDLE;
            ST_POP_IP:  if (mem_rdy) state_n = ST_POP_CS;
            ST_POP_CS:  if (mem_rdy) state_n = ST_POP_FL;
            ST_POP_FL:  if (mem_rdy) state_n = ST_RESUME;
            ST_RESUME:  state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register and captured words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            vtype  <= '0;
            ip_buf <= '0;
            cs_buf <= '0;
            fl_buf <= '0;
        end else begin
            state <= state_n;
            if (take_irq && (src != SRC_MASK)) vtype <= sel_type;
            if (state == ST_ACK) vtype <= ack_type;
            if (mem_rdy && ((state == ST_VEC_OFS) || (state == ST_POP_IP))) ip_buf <= mem_rdata;
            if (mem_rdy && ((state == ST_VEC_SEG) || (state == ST_POP_CS))) cs_buf <= mem_rdata;
            if (mem_rdy && (state == ST_POP_FL)) fl_buf <= mem_rdata;
        end
    end

    // outputs decoded from the state
    always_comb begin
        logic [DATA_W-1:0] fl_word;
        fl_word         = cur_flags;
        fl_word[IE_BIT] = ie;

        is_idle     = (state == ST_IDLE);
        nmi_take    = take_irq && (src == SRC_NMI);
        entry_clr   = 1'b0;
        restore_en  = 1'b0;
        restore_val = mem_rdata[IE_BIT];
        int_ack     = 1'b0;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;
        vec_rd      = 1'b0;
        mem_addr    = '0;
        stk_wdata   = '0;
        pc_load     = 1'b0;
        flags_load  = 1'b0;
        new_ip      = ip_buf;
        new_cs      = cs_buf;
        flags_out   = fl_buf;
        unique case (state)
            ST_ACK: int_ack = 1'b1;
            ST_PUSH_FL: begin
                stk_push  = 1'b1;
                stk_wdata = fl_word;
                entry_clr = mem_rdy;
            end
            ST_PUSH_CS: begin
                stk_push  = 1'b1;
                stk_wdata = cur_cs;
            end
            ST_PUSH_IP: begin
                stk_push  = 1'b1;
                stk_wdata = cur_ip;
            end
            ST_VEC_OFS: begin
                vec_rd   = 1'b1;
                mem_addr = {{PAD_W{1'b0}}, vtype, 2'b00};
            end
            ST_VEC_SEG: begin
                vec_rd   = 1'b1;
                mem_addr = {{PAD_W{1'b0}}, vtype, 2'b10};
            end
            ST_JUMP: pc_load = 1'b1;
            ST_POP_IP, ST_POP_CS: stk_pop = 1'b1;
            ST_POP_FL: begin
                stk_pop    = 1'b1;
                restore_en = mem_rdy;
            end
            ST_RESUME: begin
                pc_load    = 1'b1;
                flags_load = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 20,
    parameter int TYPE_W   = 8,
    parameter int IE_BIT   = 9,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_req,
    input  logic              nmi_in,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              insn_done,
    input  logic              ret_req,
    input  logic              cli_cmd,
    input  logic              sti_cmd,
    output logic              int_ack,
    input  logic [TYPE_W-1:0] ack_type,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [DATA_W-1:0] cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    output logic              stk_push,
    output logic              stk_pop,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] stk_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              pc_load,
    output logic [DATA_W-1:0] new_cs,
    output logic [DATA_W-1:0] new_ip,
    output logic              flags_load,
    output logic [DATA_W-1:0] flags_out,
    output logic              ie_flag,
    output logic              seq_busy
);
    logic              nmi_pend, nmi_take;
    irq_src_e          src;
    logic [TYPE_W-1:0] sel_type;
    logic              is_idle, entry_clr, restore_en, restore_val;

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_in),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    irq_arbiter #(.TYPE_W(TYPE_W), .NMI_TYPE(NMI_TYPE)) u_arb (
        .nmi_pend (nmi_pend),
        .swi_req  (swi_req),
        .swi_type (swi_type),
        .intr_req (intr_req),
        .ie       (ie_flag),
        .src      (src),
        .sel_type (sel_type)
    );

    irq_ie_flag u_ie (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_en      (is_idle),
        .cmd_clr     (cli_cmd),
        .cmd_set     (sti_cmd),
        .entry_clr   (entry_clr),
        .restore_en  (restore_en),
        .restore_val (restore_val),
        .ie          (ie_flag)
    );

    irq_seq_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .TYPE_W (TYPE_W),
        .IE_BIT (IE_BIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_done   (insn_done),
        .go_ret      (ret_req),
        .src         (src),
        .sel_type    (sel_type),
        .ack_type    (ack_type),
        .cur_flags   (cur_flags),
        .cur_cs      (cur_cs),
        .cur_ip      (cur_ip),
        .ie          (ie_flag),
        .mem_rdy     (mem_rdy),
        .mem_rdata   (mem_rdata),
        .is_idle     (is_idle),
        .nmi_take    (nmi_take),
        .entry_clr   (entry_clr),
        .restore_en  (restore_en),
        .restore_val (restore_val),
        .int_ack     (int_ack),
        .stk_push    (stk_push),
        .stk_pop     (stk_pop),
        .vec_rd      (vec_rd),
        .mem_addr    (mem_addr),
        .stk_wdata   (stk_wdata),
        .pc_load     (pc_load),
        .flags_load  (flags_load),
        .new_ip      (new_ip),
        .new_cs      (new_cs),
        .flags_out   (flags_out)
    );

    assign seq_busy = !is_idle;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_ack,
    input logic              stk_push,
    input logic              stk_pop,
    input logic              vec_rd,
    input logic              pc_load,
    input logic              flags_load,
    input logic              mem_rdy,
    input logic [DATA_W-1:0] stk_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              ie_flag,
    input logic              seq_busy
);
    // R5
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> !int_ack);

    // R6
    ack_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> stk_push);

    // R13
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push && !mem_rdy) |=> (stk_push && $stable(stk_wdata)));

    // R13
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !mem_rdy) |=> (vec_rd && $stable(mem_addr)));

    // R11
    entry_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !flags_load) |-> !ie_flag);

    // R1
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_ack, stk_push, stk_pop, vec_rd, pc_load}));

    // R7
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd |-> !mem_addr[0]);

    // R3
    ack_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> $past(ie_flag));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_busy |-> !(stk_push || stk_pop || vec_rd || pc_load));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_ack    (int_ack),
    .stk_push   (stk_push),
    .stk_pop    (stk_pop),
    .vec_rd     (vec_rd),
    .pc_load    (pc_load),
    .flags_load (flags_load),
    .mem_rdy    (mem_rdy),
    .stk_wdata  (stk_wdata),
    .mem_addr   (mem_addr),
    .ie_flag    (ie_flag),
    .seq_busy   (seq_busy)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        intr_req = 0, nmi_in = 0, swi_req = 0, insn_done = 0;
    logic        ret_req = 0, cli_cmd = 0, sti_cmd = 0;
    logic [7:0]  swi_type = 0, ack_type = 0;
    logic [15:0] cur_flags = 0, cur_cs = 0, cur_ip = 0;
    logic [15:0] mem_rdata = 0;
    logic        mem_rdy = 0;
    logic        int_ack, stk_push, stk_pop, vec_rd, pc_load, flags_load, ie_flag, seq_busy;
    logic [19:0] mem_addr;
    logic [15:0] stk_wdata, new_cs, new_ip, flags_out;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .intr_req(intr_req), .nmi_in(nmi_in),
        .swi_req(swi_req), .swi_type(swi_type), .insn_done(insn_done),
        .ret_req(ret_req), .cli_cmd(cli_cmd), .sti_cmd(sti_cmd),
        .int_ack(int_ack), .ack_type(ack_type), .cur_flags(cur_flags),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .stk_push(stk_push), .stk_pop(stk_pop),
        .vec_rd(vec_rd), .mem_addr(mem_addr), .stk_wdata(stk_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .pc_load(pc_load),
        .new_cs(new_cs), .new_ip(new_ip), .flags_load(flags_load),
        .flags_out(flags_out), .ie_flag(ie_flag), .seq_busy(seq_busy)
    );

    always #5 clk = ~clk;

    int nchecks = 0;
    int nerr = 0;
    int lat = 0;
    int wcnt = 0;
    bit quiet = 0;
    int mem_stack[$];
    int exp_k[$], exp_v[$], act_k[$], act_v[$];

    // reference vector table contents
    function automatic int vecval(int a);
        return (a * 7 + 'h300) & 'hffff;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // memory responder and event monitor, evaluated once per clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rdy) begin
                mem_rdy <= 1'b0;
                wcnt = 0;
            end else if (stk_push || stk_pop || vec_rd) begin
                if (wcnt >= lat) begin
                    mem_rdy <= 1'b1;
                    if (stk_push) begin
                        mem_stack.push_back(int'(stk_wdata));
                        act_k.push_back(1); act_v.push_back(int'(stk_wdata));
                    end else if (stk_pop) begin
                        int v;
                        v = (mem_stack.size() > 0) ? mem_stack.pop_back() : 0;
                        mem_rdata <= v[15:0];
                        act_k.push_back(2); act_v.push_back(v);
                    end else begin
                        mem_rdata <= 16'(vecval(int'(mem_addr)));
                        act_k.push_back(3); act_v.push_back(int'(mem_addr));
                    end
                end else begin
                    wcnt++;
                end
            end
            if (pc_load) begin
                act_k.push_back(4); act_v.push_back(int'(new_ip));
                act_k.push_back(5); act_v.push_back(int'(new_cs));
                if (flags_load) begin
                    act_k.push_back(6); act_v.push_back(int'(flags_out));
                end
            end
            if (int_ack) begin
                act_k.push_back(7); act_v.push_back(0);
            end
            if (quiet && (stk_push || stk_pop || vec_rd || int_ack || pc_load)) begin
                nerr++;
                $display("FAIL R2 strobe while quiet: actual=1 expected=0");
            end
        end
    end

    task automatic ex(int k, int v);
        exp_k.push_back(k); exp_v.push_back(v);
    endtask

    task automatic expect_entry(bit ack, int t, int fl, int cs, int ip);
        if (ack) ex(7, 0);
        ex(1, fl); ex(1, cs); ex(1, ip);
        ex(3, 4 * t); ex(3, 4 * t + 2);
        ex(4, vecval(4 * t)); ex(5, vecval(4 * t + 2));
    endtask

    task automatic expect_return(int ip, int cs, int fl);
        ex(2, ip); ex(2, cs); ex(2, fl);
        ex(4, ip); ex(5, cs); ex(6, fl);
    endtask

    task automatic compare_log(string req, string what);
        bit ok;
        int bad_a, bad_e;
        ok = (exp_k.size() == act_k.size());
        bad_a = act_k.size(); bad_e = exp_k.size();
        if (ok) begin
            foreach (exp_k[i]) begin
                if (ok && (exp_k[i] != act_k[i] || exp_v[i] != act_v[i])) begin
                    ok = 0;
                    bad_a = act_k[i] * 'h100000 + act_v[i];
                    bad_e = exp_k[i] * 'h100000 + exp_v[i];
                end
            end
        end
        chk(ok, req, what, bad_a, bad_e);
        exp_k.delete(); exp_v.delete(); act_k.delete(); act_v.delete();
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk); insn_done = 1;
        @(negedge clk); insn_done = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (seq_busy && n < 300) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
    endtask

    task automatic do_ret();
        @(negedge clk); ret_req = 1;
        @(negedge clk); ret_req = 0;
        wait_idle();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++; nchecks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ie_flag == 0, "R1", "enable after reset", ie_flag, 0);
        chk(seq_busy == 0, "R1", "busy after reset", seq_busy, 0);
        chk(int_ack == 0, "R1", "ack after reset", int_ack, 0);

        // R3 maskable ignored with enable 0
        quiet = 1;
        intr_req = 1;
        boundary(); tick(5);
        chk(seq_busy == 0, "R3", "masked request started entry", seq_busy, 0);
        quiet = 0;
        compare_log("R3", "no activity while masked");

        // R4 set enable
        @(negedge clk); sti_cmd = 1; @(negedge clk); sti_cmd = 0;
        chk(ie_flag == 1, "R4", "set-enable", ie_flag, 1);

        // R2 no boundary, no entry
        quiet = 1; tick(6); quiet = 0;
        compare_log("R2", "request without boundary");

        // R5 R6 R7 maskable entry, zero wait
        lat = 0; ack_type = 8'h21;
        cur_flags = 16'h0046; cur_cs = 16'h1234; cur_ip = 16'h5678;
        expect_entry(1, 'h21, 'h0246, 'h1234, 'h5678);
        boundary(); wait_idle();
        intr_req = 0;
        compare_log("R5", "maskable entry sequence (R6 R7)");
        // R11
        chk(ie_flag == 0, "R11", "enable cleared on entry", ie_flag, 0);

        // R12 return, two waits
        lat = 2;
        expect_return('h5678, 'h1234, 'h0246);
        do_ret();
        compare_log("R12", "return sequence");
        chk(ie_flag == 1, "R12", "enable restored", ie_flag, 1);

        // R4 clear beats set
        @(negedge clk); cli_cmd = 1; sti_cmd = 1; @(negedge clk); cli_cmd = 0; sti_cmd = 0;
        chk(ie_flag == 0, "R4", "clear wins over set", ie_flag, 0);

        // R9 short NMI pulse before boundary, R8 type 2, R3 unaffected by enable
        lat = 1; cur_flags = 16'h0246; cur_cs = 16'h0a00; cur_ip = 16'h0100;
        @(negedge clk); nmi_in = 1; @(negedge clk); nmi_in = 0;
        quiet = 1; tick(4); quiet = 0;
        compare_log("R9", "pulse waits for boundary");
        expect_entry(0, 2, 'h0046, 'h0a00, 'h0100);
        boundary(); wait_idle();
        compare_log("R8", "NMI entry at 8 and 10 (R9)");
        lat = 0;
        expect_return('h0100, 'h0a00, 'h0046);
        do_ret();
        compare_log("R12", "return after NMI");
        chk(ie_flag == 0, "R12", "enable restored to 0", ie_flag, 0);

        // R10 NMI beats maskable, three waits (R13)
        @(negedge clk); sti_cmd = 1; @(negedge clk); sti_cmd = 0;
        lat = 3; cur_flags = 16'h0002; cur_cs = 16'h2000; cur_ip = 16'h0030;
        intr_req = 1; ack_type = 8'h40;
        @(negedge clk); nmi_in = 1; @(negedge clk); nmi_in = 0;
        expect_entry(0, 2, 'h0202, 'h2000, 'h0030);
        boundary(); wait_idle();
        compare_log("R10", "NMI beats maskable (R13 waits)");
        quiet = 1; boundary(); tick(3); quiet = 0;
        compare_log("R11", "maskable held off after entry");
        intr_req = 0;
        lat = 1;
        expect_return('h0030, 'h2000, 'h0202);
        do_ret();
        compare_log("R12", "return restores enable 1");

        // R10 software beats maskable
        lat = 2; intr_req = 1; swi_req = 1; swi_type = 8'h05;
        cur_flags = 16'h0010; cur_cs = 16'h3000; cur_ip = 16'h0044;
        expect_entry(0, 5, 'h0210, 'h3000, 'h0044);
        boundary(); swi_req = 0; wait_idle();
        intr_req = 0;
        compare_log("R10", "software beats maskable");

        // R10 return beats a latched NMI at a boundary
        @(negedge clk); nmi_in = 1; @(negedge clk); nmi_in = 0;
        expect_return('h0044, 'h3000, 'h0210);
        @(negedge clk); ret_req = 1; insn_done = 1;
        @(negedge clk); ret_req = 0; insn_done = 0;
        wait_idle();
        compare_log("R10", "return beats NMI");
        cur_flags = 16'h0000; cur_cs = 16'h4000; cur_ip = 16'h0066;
        expect_entry(0, 2, 'h0200, 'h4000, 'h0066);
        boundary(); wait_idle();
        compare_log("R9", "latched NMI taken after return");
        expect_return('h0066, 'h4000, 'h0200);
        do_ret();
        compare_log("R13", "each access once");

        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule